// File: doc/BRIEF.md
# Bit-Serial Attention Score Engine

This block computes one attention score per token pair as the quadratic form s = Σᵢ Σⱼ xᵢ·Wᵢⱼ·yⱼ. The query and key projections are folded ahead of time into a single combined matrix W. W stays resident in a small register-file store, and raw token vectors are applied straight against it. No query or key vector is ever formed. The block has no multiplier. Each partial product comes from gating stored weight words with single input bits, followed by a shift and an add or subtract.

The two vectors are consumed one bit-plane pair at a time. The y plane index is the outer loop and the x plane index is the inner loop, both running from LSB to MSB. In each cycle, only the storage rows whose x bit is 1 take part. Inside those rows, only the columns whose y bit is 1 are summed. A plane pair in which either plane is all zero costs no cycle. Depending on whether the plane pair involves sign bits, its row sum falls into one of four groups: sign×sign, sign×magnitude, magnitude×sign or magnitude×magnitude. Each row sum is shifted by the sum of the two plane indices. It is subtracted when exactly one of the two planes is a sign plane, and added otherwise.

Software or a loader fills W through a row-wide write port. A producer then hands over one (x, y) pair per transfer on a valid/ready port. The score appears on a registered output together with a one-cycle valid pulse.

Top module: `attn_score_engine`

## Requirements
- R1: For N=8 element vectors x and y and an 8×8 matrix W, all 8-bit two's complement, out_score equals Σᵢ Σⱼ xᵢ·Wᵢⱼ·yⱼ as a 40-bit signed value. Element i of in_x/in_y sits at bits [8i+7:8i], and Wᵢⱼ sits at bits [8j+7:8j] of row i.
- R2: A cycle with wr_en high writes wr_data into row wr_row. The new row is used by every transfer accepted after that edge.
- R3: The accumulator never leaves the range of a 31-bit signed value for any inputs, so no wrap occurs in the 40-bit result.
- R4: A transfer is accepted on an edge where in_valid and in_ready are both high. in_ready is low from the cycle after acceptance up to the cycle in which out_valid is high, and it is high again in that cycle.
- R5: out_valid is high for exactly one cycle per accepted transfer. out_score changes only in that cycle and then holds.
- R6: Let nx be the number of bit positions set in at least one x element, and ny the same for y. out_valid is high exactly nx·ny+1 clock edges after the accepting edge.
- R7: If either vector is all zero, the score is 0 and out_valid follows one edge after acceptance.
- R8: in_valid and new vector values presented while a computation is running are ignored. The pending result is unchanged.
- R9: After reset, out_valid is 0, in_ready is 1 and out_score is 0.
- R10: Operands of -128 in x, y or W give exact results. This covers the sign×sign group, which is added, and the two mixed-sign groups, which are subtracted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Weight row write strobe |
| wr_row | input | 3 | Row index to write |
| wr_data | input | 64 | Eight signed 8-bit weights of the row |
| in_valid | input | 1 | Token pair offered |
| in_ready | output | 1 | Engine idle, able to accept |
| in_x | input | 64 | Eight signed 8-bit x elements |
| in_y | input | 64 | Eight signed 8-bit y elements |
| out_valid | output | 1 | One-cycle result strobe |
| out_score | output | 40 | Signed score, held until the next result |

## Verification
The assertions assume that W is written with every row defined before the first transfer, and that W is not rewritten while a computation is running, since the read path sees the store live. The bench loads every row at the start of each phase. It issues weight writes only between transfers, after out_valid has been seen. It drives in_valid during a busy computation only in the dedicated test of R8. The sweeps stay inside the 8-bit signed input range and include the -128 extremes, so the overflow bound that the accumulator check relies on always applies.

// File: rtl/attn_pkg.sv
package attn_pkg;

  typedef enum logic [1:0] {
    GRP_MM = 2'd0,
    GRP_MS = 2'd1,
    GRP_SM = 2'd2,
    GRP_SS = 2'd3
  } plane_grp_t;

  function automatic logic grp_is_negative(input plane_grp_t g);
    return (g == GRP_MS) || (g == GRP_SM);
  endfunction

endpackage

// File: rtl/weight_store.sv
module weight_store #(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [$clog2(N)-1:0]  wr_row,
  input  logic [N*DW-1:0]       wr_data,
  output logic [N*N*DW-1:0]     rd_rows
);

  logic [N*DW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_row] <= wr_data;
  end

  for (genvar r = 0; r < N; r++) begin : g_rd
    assign rd_rows[r*N*DW +: N*DW] = mem[r];
  end

endmodule

// File: rtl/plane_sched.sv
module plane_sched #(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [N*DW-1:0]       x_vec,
  input  logic [N*DW-1:0]       y_vec,
  input  logic                  step,
  output logic                  found,
  output logic [$clog2(DW)-1:0] pick_a,
  output logic [$clog2(DW)-1:0] pick_b
);

  localparam int BW = $clog2(DW);
  localparam int PAIRS = DW * DW;

  logic [DW-1:0]    x_plane_nz, y_plane_nz;
  logic [PAIRS-1:0] pair_mask, pending;
  logic [2*BW-1:0]  idx;

  for (genvar p = 0; p < DW; p++) begin : g_plane
    logic [N-1:0] xb, yb;
    for (genvar e = 0; e < N; e++) begin : g_elem
      assign xb[e] = x_vec[e*DW + p];
      assign yb[e] = y_vec[e*DW + p];
    end
    assign x_plane_nz[p] = |xb;
    assign y_plane_nz[p] = |yb;
  end

  for (genvar b = 0; b < DW; b++) begin : g_pb
    for (genvar a = 0; a < DW; a++) begin : g_pa
      assign pair_mask[b*DW + a] = y_plane_nz[b] & x_plane_nz[a];
    end
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = PAIRS - 1; k >= 0; k--) begin
      if (pending[k]) begin
        found = 1'b1;
        idx   = (2*BW)'(k);
      end
    end
  end

  assign pick_a = idx[BW-1:0];
  assign pick_b = idx[2*BW-1:BW];

  always_ff @(posedge clk) begin
    if (rst)                pending <= '0;
    else if (load)          pending <= pair_mask;
    else if (step && found) pending[idx] <= 1'b0;
  end

  // R6: every productive step retires exactly one plane pair
  a_r6_one_pair_per_step: assert property (@(posedge clk) disable iff (rst)
    (step && found && !load) |=> ($countones(pending) == $countones($past(pending)) - 1));

  // R7: a load never enqueues work for an all-zero vector
  a_r7_zero_no_work: assert property (@(posedge clk) disable iff (rst)
    (load && (x_vec == '0 || y_vec == '0)) |=> !found);

endmodule

// File: rtl/gated_rowsum.sv
module gated_rowsum #(
  parameter int N    = 8,
  parameter int DW   = 8,
  parameter int RS_W = 15
) (
  input  logic [N*N*DW-1:0]        rows,
  input  logic [N*DW-1:0]          x_vec,
  input  logic [N*DW-1:0]          y_vec,
  input  logic [$clog2(DW)-1:0]    a_sel,
  input  logic [$clog2(DW)-1:0]    b_sel,
  output logic signed [RS_W-1:0]   total
);

  logic [N-1:0] row_en, col_en;
  logic signed [RS_W-1:0] row_part [N];

  for (genvar e = 0; e < N; e++) begin : g_en
    assign row_en[e] = x_vec[e*DW + int'(a_sel)];
    assign col_en[e] = y_vec[e*DW + int'(b_sel)];
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    always_comb begin
      row_part[i] = '0;
      if (row_en[i]) begin
        for (int j = 0; j < N; j++) begin
          if (col_en[j]) begin
            row_part[i] = row_part[i] +
              RS_W'($signed(rows[(i*N + j)*DW +: DW]));
          end
        end
      end
    end
  end

  always_comb begin
    total = '0;
    for (int i = 0; i < N; i++) total = total + row_part[i];
  end

endmodule

// File: rtl/attn_score_engine.sv
module attn_score_engine
  import attn_pkg::*;
#(
  parameter int N     = 8,
  parameter int DW    = 8,
  parameter int ACC_W = 40
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(N)-1:0]     wr_row,
  input  logic [N*DW-1:0]          wr_data,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [N*DW-1:0]          in_x,
  input  logic [N*DW-1:0]          in_y,
  output logic                     out_valid,
  output logic signed [ACC_W-1:0]  out_score
);

  localparam int BW     = $clog2(DW);
  localparam int RS_W   = DW + 2*$clog2(N) + 1;
  localparam int SAFE_W = 2*DW + RS_W;

  logic                     busy;
  logic [N*DW-1:0]          x_q, y_q;
  logic [N*N*DW-1:0]        rows;
  logic                     found;
  logic [BW-1:0]            pick_a, pick_b;
  logic signed [RS_W-1:0]   rsum;
  logic signed [ACC_W-1:0]  acc, term;
  plane_grp_t               grp;
  logic                     accept;

  assign in_ready = !busy;
  assign accept   = in_valid && !busy;

  weight_store #(.N(N), .DW(DW)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
    .rd_rows(rows)
  );

  plane_sched #(.N(N), .DW(DW)) u_sched (
    .clk(clk), .rst(rst), .load(accept), .x_vec(in_x), .y_vec(in_y),
    .step(busy), .found(found), .pick_a(pick_a), .pick_b(pick_b)
  );

  gated_rowsum #(.N(N), .DW(DW), .RS_W(RS_W)) u_rowsum (
    .rows(rows), .x_vec(x_q), .y_vec(y_q), .a_sel(pick_a), .b_sel(pick_b),
    .total(rsum)
  );

  always_comb begin
    grp = plane_grp_t'({pick_b == BW'(DW-1), pick_a == BW'(DW-1)});
    term = ACC_W'(rsum) <<< (int'(pick_a) + int'(pick_b));
    if (grp_is_negative(grp)) term = -term;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_score <= '0;
      x_q       <= '0;
      y_q       <= '0;
    end else begin
      out_valid <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        acc  <= '0;
        x_q  <= in_x;
        y_q  <= in_y;
      end else if (busy) begin
        if (found) begin
          acc <= acc + term;
        end else begin
          busy      <= 1'b0;
          out_valid <= 1'b1;
          out_score <= acc;
        end
      end
    end
  end

  a_r4_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  a_r4_ready_with_result: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_ready);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  a_r5_score_holds: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_score));

  a_r8_operands_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(x_q) && $stable(y_q)));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    busy |-> ((acc[ACC_W-1:SAFE_W-1] == '0) || (&acc[ACC_W-1:SAFE_W-1])));

endmodule

// File: tb/attn_score_engine_tb_top.sv
`timescale 1ns/1ps
module attn_score_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_row;
  logic [63:0] wr_data;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_x, in_y;
  logic        out_valid;
  logic signed [39:0] out_score;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic signed [7:0] wm [8][8];
  logic signed [7:0] xv [8];
  logic signed [7:0] yv [8];

  always #4 clk = ~clk;

  attn_score_engine dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_score(out_score)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_w();
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      wr_en  = 1'b1;
      wr_row = 3'(r);
      for (int c = 0; c < 8; c++) wr_data[c*8 +: 8] = wm[r][c];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_tx(input string req, input bit junk);
    longint exp_s = 0;
    int nx = 0, ny = 0, cnt = 0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        exp_s += longint'(xv[i]) * longint'(wm[i][j]) * longint'(yv[j]);
    for (int p = 0; p < 8; p++) begin
      bit ox = 0, oy = 0;
      for (int e = 0; e < 8; e++) begin
        ox |= xv[e][p];
        oy |= yv[e][p];
      end
      nx += int'(ox);
      ny += int'(oy);
    end
    @(negedge clk);
    for (int e = 0; e < 8; e++) begin
      in_x[e*8 +: 8] = xv[e];
      in_y[e*8 +: 8] = yv[e];
    end
    in_valid = 1'b1;
    check({req, "/R4 ready before"}, longint'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    if (junk) begin
      in_x = ~in_x;          // R8: offered while busy, must be ignored
      in_y = in_y ^ 64'h5a5a_5a5a_5a5a_5a5a;
    end else begin
      in_valid = 1'b0;
    end
    check({req, "/R4 ready busy"}, longint'(in_ready), 0);
    while (!out_valid && cnt < 200) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      in_valid = 1'b0;
    end
    check(req, out_score, exp_s);
    check({req, "/R6 latency"}, cnt, nx * ny + 1);
    check({req, "/R4 ready at result"}, longint'(in_ready), 1);
    @(negedge clk);
    check({req, "/R5 pulse"}, longint'(out_valid), 0);
    check({req, "/R5 hold"}, out_score, exp_s);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_row = '0; wr_data = '0;
    in_valid = 1'b0; in_x = '0; in_y = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check("R9 out_valid", longint'(out_valid), 0);
    check("R9 in_ready", longint'(in_ready), 1);
    check("R9 score", out_score, 0);

    // Phase 1: random W, random vectors (R1, R2)
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) wm[r][c] = 8'($urandom);
    load_w();
    for (int t = 0; t < 150; t++) begin
      for (int e = 0; e < 8; e++) begin
        xv[e] = 8'($urandom);
        yv[e] = 8'($urandom);
      end
      run_tx("R1 random", 1'b0);
    end

    // R7: all-zero x, then all-zero y
    for (int e = 0; e < 8; e++) begin xv[e] = 0; yv[e] = 8'($urandom); end
    run_tx("R7 zero x", 1'b0);
    for (int e = 0; e < 8; e++) begin xv[e] = 8'($urandom); yv[e] = 0; end
    run_tx("R7 zero y", 1'b0);

    // R8: junk offered while busy
    for (int t = 0; t < 10; t++) begin
      for (int e = 0; e < 8; e++) begin
        xv[e] = 8'($urandom) | 8'h01;
        yv[e] = 8'($urandom) | 8'h01;
      end
      run_tx("R8 ignore busy", 1'b1);
    end

    // R2 reload of W, then R10 extremes
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) wm[r][c] = -8'sd128;
    load_w();
    for (int e = 0; e < 8; e++) begin xv[e] = -8'sd128; yv[e] = -8'sd128; end
    run_tx("R10 R3 all min", 1'b0);
    for (int e = 0; e < 8; e++) begin xv[e] = -8'sd128; yv[e] = 8'sd127; end
    run_tx("R10 R3 min max", 1'b0);
    for (int e = 0; e < 8; e++) begin xv[e] = 8'sd127; yv[e] = -8'sd128; end
    run_tx("R10 R3 max min", 1'b0);
    for (int e = 0; e < 8; e++) begin xv[e] = -8'sd1; yv[e] = -8'sd1; end
    run_tx("R10 all ones", 1'b0);

    // R2: change one row, scores must follow
    wm[3][5] = 8'sd77;
    load_w();
    for (int e = 0; e < 8; e++) begin xv[e] = 8'($urandom); yv[e] = 8'($urandom); end
    run_tx("R2 reload", 1'b0);

    // Near-exhaustive scalar sweep over x0, y0 (R1, R6, R10)
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) wm[r][c] = 8'($urandom);
    wm[0][0] = -8'sd128;
    load_w();
    for (int e = 0; e < 8; e++) begin xv[e] = 0; yv[e] = 0; end
    for (int u = 0; u <= 32; u++) begin
      for (int v = 0; v <= 32; v++) begin
        xv[0] = (u == 32) ? 8'sd127 : 8'(-128 + 8*u);
        yv[0] = (v == 32) ? 8'sd127 : 8'(-128 + 8*v);
        run_tx("R1 R10 sweep", 1'b0);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule